// File: doc/BRIEF.md
# Byte-Port Sample Buffer with Event Status

This block sits between a data converter and an 8-bit host register port. Each conversion result is 16 bits wide. It is pushed into a deep first-in first-out store and held there until the host collects it. The host reads one sample as two byte accesses to the same data port: the low byte first, then the high byte. The stored entry leaves the buffer only once its high byte has been returned.

A second port returns an 8-bit status byte, which carries two kinds of flag. Level flags show the buffer occupancy and whether acquisition is active. Sticky event flags record a discarded sample, an end-of-scan marker and the crossing of a half-depth threshold. Reading the status byte clears the event flags, except for any event raised in that same cycle. A one-cycle flush strobe empties the buffer and restarts the byte sequence.

Top module: `sample_fifo_port`

## Requirements
- R1: After reset the buffer is empty and no event flag is set. With `conv_active` low, a status read returns 0x81.
- R2: A data-port read returns the oldest sample in two steps: the low byte, then the high byte. Samples come out in the order they were written. The entry is removed only after its high byte has been read.
- R3: Status bit positions are: bit7 idle (= not `conv_active`), bit6 running (= `conv_active`), bit5 data lost, bit4 end of scan, bit3 threshold, bit2 full (occupancy equals DEPTH), bit1 near-full (occupancy at least DEPTH-16), bit0 empty (occupancy zero).
- R4: A status read clears bits 5, 4 and 3 from the next cycle on. An event raised in the same cycle as the status read stays set.
- R5: A flush strobe empties the buffer and resets the byte phase. A write or data read in the same cycle has no effect and raises no event.
- R6: A write that arrives while the buffer is full is dropped, and it sets the data-lost flag (bit5). The stored contents are left unchanged.
- R7: The threshold flag (bit3) is set when occupancy moves from below 2048 to 2048 or more.
- R8: A data read while the buffer is empty returns 0x00 and leaves the buffer and the byte phase unchanged.
- R9: A pulse on `scan_end` sets the end-of-scan flag (bit4).
- R10: When a status read and a data read happen in the same cycle, the status byte is returned. The data read has no effect.
- R11: Samples are stored and returned bit-exact as two's-complement values, including 0x8000 and 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Push one sample from the converter |
| wr_data | input | 16 | Two's-complement sample to push |
| scan_end | input | 1 | End-of-scan event pulse |
| conv_active | input | 1 | Acquisition running level |
| flush | input | 1 | One-cycle command strobe that empties the buffer |
| rd_data | input | 1 | Host read strobe for the data port |
| rd_stat | input | 1 | Host read strobe for the status port |
| host_rdata | output | 8 | Byte returned for the current read strobe (0 when none) |

## Verification
The bench fills the buffer past the threshold and past the near-full mark up to full, then writes once more. A design with an off-by-one in either flag would raise it one sample early or late. A design that accepts the extra write would overwrite the oldest sample or wrap the occupancy. Status reads are placed in the same cycle as new end-of-scan pulses, where a design that lets the clear win would lose the event. Flushes are issued between the low and high byte of a sample, and data reads are made on an empty buffer. A design that kept its byte phase across the flush, or advanced on an empty read, would return bytes in the wrong order from then on. Colliding status and data strobes expose a design that quietly advances the byte phase behind the returned status.

// File: rtl/sfp_pkg.sv
`timescale 1ns/1ps
package sfp_pkg;
    // Status byte bit positions (host software decodes these)
    localparam int ST_IDLE  = 7;
    localparam int ST_RUN   = 6;
    localparam int ST_LOST  = 5;
    localparam int ST_EOS   = 4;
    localparam int ST_THR   = 3;
    localparam int ST_FULL  = 2;
    localparam int ST_NEAR  = 1;
    localparam int ST_EMPTY = 0;

    typedef struct packed {
        logic lost;
        logic eos;
        logic thr;
    } sfp_ev_t;
endpackage

// File: rtl/sfp_store.sv
`timescale 1ns/1ps
module sfp_store #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 4096,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sfp_levels.sv
`timescale 1ns/1ps
module sfp_levels #(
    parameter int DEPTH  = 4096,
    parameter int MARGIN = 16,
    parameter int THRESH = 2048,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic [CW-1:0] cnt_q,
    input  logic [CW-1:0] cnt_d,
    output logic          full,
    output logic          near,
    output logic          empty,
    output logic          thr_cross
);
    localparam logic [CW-1:0] FULL_AT = CW'(DEPTH);
    localparam logic [CW-1:0] NEAR_AT = CW'(DEPTH - MARGIN);
    localparam logic [CW-1:0] THR_AT  = CW'(THRESH);

    always_comb begin
        full      = (cnt_q == FULL_AT);
        near      = (cnt_q >= NEAR_AT);
        empty     = (cnt_q == '0);
        thr_cross = (cnt_q < THR_AT) && (cnt_d >= THR_AT);
    end
endmodule

// File: rtl/sfp_events.sv
`timescale 1ns/1ps
module sfp_events
    import sfp_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    clr,
    input  sfp_ev_t set,
    output sfp_ev_t ev_q
);
    sfp_ev_t ev_d;

    // Setting wins over the clear so a same-cycle event survives
    always_comb begin
        ev_d = clr ? '0 : ev_q;
        ev_d.lost = ev_d.lost | set.lost;
        ev_d.eos  = ev_d.eos  | set.eos;
        ev_d.thr  = ev_d.thr  | set.thr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= ev_d;
    end
endmodule

// File: rtl/sample_fifo_port.sv
`timescale 1ns/1ps
module sample_fifo_port
    import sfp_pkg::*;
#(
    parameter int WIDTH  = 16,
    parameter int DEPTH  = 4096,
    parameter int MARGIN = 16,
    parameter int THRESH = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             scan_end,
    input  logic             conv_active,
    input  logic             flush,
    input  logic             rd_data,
    input  logic             rd_stat,
    output logic [7:0]       host_rdata
);
    localparam int AW    = $clog2(DEPTH);
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int BYTES = WIDTH / 8;
    localparam int PW    = (BYTES > 1) ? $clog2(BYTES) : 1;
    localparam logic [PW-1:0] LAST = PW'(BYTES - 1);

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [CW-1:0] cnt;
        logic [PW-1:0] phase;
    } state_t;

    state_t st_q, st_d;
    logic full, near, empty, thr_cross;
    logic push_ok, pop, data_rd;
    logic [WIDTH-1:0] head;
    logic [7:0] byte_sel;
    logic [7:0] status;
    sfp_ev_t ev_set, ev_q;

    // ---------------- next-state ----------------
    always_comb begin
        st_d    = st_q;
        data_rd = rd_data && !rd_stat;
        push_ok = wr_en && !flush && !full;
        pop     = 1'b0;
        if (flush) begin
            st_d = '0;
        end else begin
            if (data_rd && !empty) begin
                if (st_q.phase == LAST) begin
                    pop        = 1'b1;
                    st_d.phase = '0;
                    st_d.rptr  = st_q.rptr + 1'b1;
                end else begin
                    st_d.phase = st_q.phase + 1'b1;
                end
            end
            if (push_ok) st_d.wptr = st_q.wptr + 1'b1;
            st_d.cnt = st_q.cnt + CW'(push_ok) - CW'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // ---------------- storage ----------------
    sfp_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) store_i (
        .clk   (clk),
        .we    (push_ok),
        .waddr (st_q.wptr),
        .wdata (wr_data),
        .raddr (st_q.rptr),
        .rdata (head)
    );

    // ---------------- flags ----------------
    sfp_levels #(.DEPTH(DEPTH), .MARGIN(MARGIN), .THRESH(THRESH)) levels_i (
        .cnt_q     (st_q.cnt),
        .cnt_d     (st_d.cnt),
        .full      (full),
        .near      (near),
        .empty     (empty),
        .thr_cross (thr_cross)
    );

    always_comb begin
        ev_set.lost = wr_en && !flush && full;
        ev_set.eos  = scan_end;
        ev_set.thr  = thr_cross;
    end

    sfp_events events_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rd_stat),
        .set   (ev_set),
        .ev_q  (ev_q)
    );

    // ---------------- host read mux ----------------
    always_comb begin
        byte_sel          = head[8*st_q.phase +: 8];
        status            = '0;
        status[ST_IDLE]   = !conv_active;
        status[ST_RUN]    = conv_active;
        status[ST_LOST]   = ev_q.lost;
        status[ST_EOS]    = ev_q.eos;
        status[ST_THR]    = ev_q.thr;
        status[ST_FULL]   = full;
        status[ST_NEAR]   = near;
        status[ST_EMPTY]  = empty;
        if (rd_stat)                host_rdata = status;
        else if (rd_data && !empty) host_rdata = byte_sel;
        else                        host_rdata = '0;
    end
endmodule

// File: rtl/sfp_checker.sv
`timescale 1ns/1ps
module sfp_checker #(
    parameter int DEPTH = 4096,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          scan_end,
    input logic          flush,
    input logic          rd_data,
    input logic          rd_stat,
    input logic [7:0]    host_rdata,
    input logic [CW-1:0] cnt,
    input logic          phase0,
    input logic [2:0]    ev
);
    // R7 / R6: occupancy never exceeds the depth
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    // R2: the low-byte read never removes an entry
    a_r2_keep_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !rd_stat && !flush && phase0 && cnt != '0) |=> cnt >= $past(cnt));

    // R5: flush leaves the buffer empty
    a_r5_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> cnt == '0);

    // R6: a write into a full buffer raises data lost
    a_r6_lost_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush && cnt == CW'(DEPTH)) |=> ev[2]);

    // R4: with no new event source, a status read clears every event
    a_r4_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !scan_end && !wr_en) |=> ev == 3'b000);

    // R9: end-of-scan pulse is recorded
    a_r9_eos_set: assert property (@(posedge clk) disable iff (!rst_n)
        scan_end |=> ev[1]);

    // R8: empty data read returns zero
    a_r8_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !rd_stat && cnt == '0) |-> host_rdata == 8'h00);

    // R3: full and empty are never reported together
    a_r3_full_empty_excl: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |-> $onehot0({host_rdata[2], host_rdata[0]}));
endmodule

bind sample_fifo_port sfp_checker #(.DEPTH(DEPTH)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .scan_end   (scan_end),
    .flush      (flush),
    .rd_data    (rd_data),
    .rd_stat    (rd_stat),
    .host_rdata (host_rdata),
    .cnt        (st_q.cnt),
    .phase0     (st_q.phase == '0),
    .ev         (ev_q)
);

// File: tb/sample_fifo_port_tb.sv
`timescale 1ns/1ps
module sample_fifo_port_tb_top;
    localparam int DEPTH  = 4096;
    localparam int MARGIN = 16;
    localparam int THRESH = 2048;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        scan_end = 1'b0;
    logic        conv_active = 1'b0;
    logic        flush = 1'b0;
    logic        rd_data = 1'b0;
    logic        rd_stat = 1'b0;
    logic [7:0]  host_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    logic [15:0] mq[$];
    int  m_phase = 0;
    bit  m_lost = 0, m_eos = 0, m_thr = 0;

    always #10 clk = ~clk;

    sample_fifo_port #(.WIDTH(16), .DEPTH(DEPTH), .MARGIN(MARGIN), .THRESH(THRESH)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .scan_end(scan_end), .conv_active(conv_active), .flush(flush),
        .rd_data(rd_data), .rd_stat(rd_stat), .host_rdata(host_rdata)
    );

    function automatic logic [7:0] model_status();
        logic [7:0] s;
        s = '0;
        s[7] = !conv_active;
        s[6] = conv_active;
        s[5] = m_lost;
        s[4] = m_eos;
        s[3] = m_thr;
        s[2] = (mq.size() == DEPTH);
        s[1] = (mq.size() >= DEPTH - MARGIN);
        s[0] = (mq.size() == 0);
        return s;
    endfunction

    function automatic logic [7:0] model_out();
        if (rd_stat) return model_status();
        if (rd_data && mq.size() != 0)
            return (m_phase == 0) ? mq[0][7:0] : mq[0][15:8];
        return 8'h00;
    endfunction

    // One clock: drive, compare before the edge, advance the model after it
    task automatic step(input bit wr, input logic [15:0] wd, input bit eos,
                        input bit rs, input bit rd, input bit fl, input string tag);
        logic [7:0] exp_v;
        int pre, post;
        bit popped;
        @(negedge clk);
        wr_en = wr; wr_data = wd; scan_end = eos;
        rd_stat = rs; rd_data = rd; flush = fl;
        #2;
        exp_v = model_out();
        checks++;
        if (host_rdata !== exp_v) begin
            fails++;
            $display("FAIL %s: host_rdata actual %h expected %h at %0t", tag, host_rdata, exp_v, $time);
        end
        @(posedge clk);
        pre = mq.size();
        popped = 0;
        if (fl) begin
            mq.delete();
            m_phase = 0;
        end else begin
            if (rd && !rs && pre != 0) begin
                if (m_phase == 1) begin
                    void'(mq.pop_front());
                    m_phase = 0;
                    popped = 1;
                end else m_phase = 1;
            end
            if (wr && pre != DEPTH) mq.push_back(wd);
        end
        post = mq.size();
        if (rs) begin m_lost = 0; m_eos = 0; m_thr = 0; end
        if (wr && !fl && pre == DEPTH) m_lost = 1;
        if (eos) m_eos = 1;
        if (!fl && pre < THRESH && post >= THRESH) m_thr = 1;
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_up();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        step(0, 0, 0, 1, 0, 0, "R1");
        // R8 empty data read returns zero and changes nothing
        step(0, 0, 0, 0, 1, 0, "R8");
        step(0, 0, 0, 0, 1, 0, "R8");
        step(0, 0, 0, 1, 0, 0, "R8");

        // R2 / R11 ordering and two's-complement values
        step(1, 16'h8000, 0, 0, 0, 0, "R11");
        step(1, 16'hFFFF, 0, 0, 0, 0, "R11");
        step(1, 16'h1234, 0, 0, 0, 0, "R2");
        for (int i = 0; i < 6; i++) step(0, 0, 0, 0, 1, 0, "R2");
        step(0, 0, 0, 0, 1, 0, "R8");

        // R3 running level
        conv_active = 1'b1;
        step(0, 0, 0, 1, 0, 0, "R3");

        // R9 / R4 end of scan, event during status read stays set
        step(0, 0, 1, 0, 0, 0, "R9");
        step(0, 0, 1, 1, 0, 0, "R4");
        step(0, 0, 0, 1, 0, 0, "R4");
        step(0, 0, 0, 1, 0, 0, "R4");

        // R7 / R3 / R6 fill to threshold, near-full, full and beyond
        for (int i = 0; i <= DEPTH; i++) begin
            bit rs;
            rs = (i == THRESH - 1) || (i == THRESH) || (i == DEPTH - MARGIN - 1) ||
                 (i == DEPTH - MARGIN) || (i == DEPTH - 1) || (i == DEPTH);
            step(1, 16'(i * 37 + 5), 0, rs, 0, 0, (i >= DEPTH) ? "R6" : (i > THRESH + 2) ? "R3" : "R7");
        end
        step(0, 0, 0, 1, 0, 0, "R6");
        step(0, 0, 0, 1, 0, 0, "R4");

        // R10 colliding strobes, then a plain data read
        step(0, 0, 0, 1, 1, 0, "R10");
        step(0, 0, 0, 0, 1, 0, "R10");
        step(0, 0, 0, 0, 1, 0, "R2");
        for (int i = 0; i < 60; i++) step(0, 0, 0, 0, 1, 0, "R2");
        step(0, 0, 0, 1, 0, 0, "R3");

        // R5 flush mid-sample with colliding write
        conv_active = 1'b0;
        step(0, 0, 0, 0, 1, 0, "R5");
        step(1, 16'hBEEF, 0, 0, 1, 1, "R5");
        step(0, 0, 0, 1, 0, 0, "R5");
        step(0, 0, 0, 0, 1, 0, "R5");
        step(1, 16'hA55A, 0, 0, 0, 0, "R5");
        step(0, 0, 0, 0, 1, 0, "R5");
        step(0, 0, 0, 0, 1, 0, "R5");
        step(0, 0, 0, 1, 0, 0, "R1");

        done = 1'b1;
        finish_up();
    end
endmodule